// File: doc/BRIEF.md
# Burst Address Sequencer

This block produces the word address for a four-beat burst. An access starts when either of two active-low address-status strobes is sampled low: the full external address is captured and a 2-bit beat counter is cleared. On later cycles an active-low advance input steps the counter, and holding advance high suspends the burst. The two low address bits follow one of two burst orders, chosen by a static mode input. The upper bits come unchanged from the captured address.

The processor-side strobe is gated by an active-low chip enable, so a processor-side start is dropped while the chip is deselected. The controller-side strobe loads whatever the chip enable is doing. The counter never stops by itself. After four beats it returns to the starting address and keeps going for as long as advance stays low. Both the address and the beat count come straight from registers, so they change on the clock edge that sampled the command.

Top module: `burst_seq`

## Requirements
- R1: While rst_ni is low, addr_o and beat_o are zero.
- R2: At a rising clock edge with ctrl_strobe_n_i low, addr_i is captured whatever ce_n_i is. After that edge addr_o equals the captured address and beat_o is 0.
- R3: At a rising clock edge with proc_strobe_n_i low and ce_n_i low, addr_i is captured. After that edge addr_o equals the captured address and beat_o is 0.
- R4: At an edge with proc_strobe_n_i low, ce_n_i high and ctrl_strobe_n_i high, nothing is captured and the counter does not move. addr_o and beat_o keep their values.
- R5: At an edge with both strobes high and adv_n_i low, beat_o increments by one, modulo 4.
- R6: At an edge with both strobes high and adv_n_i high, addr_o and beat_o hold.
- R7: With mode_i = 1 (interleaved), addr_o[1:0] equals the captured bits [1:0] XOR beat_o. For example, a start of 01 gives 01, 00, 11, 10.
- R8: With mode_i = 0 (linear), addr_o[1:0] equals the captured bits [1:0] plus beat_o, modulo 4. For example, a start of 10 gives 10, 11, 00, 01.
- R9: addr_o[16:2] always equals bits [16:2] of the last captured address.
- R10: After four advancing beats the address returns to the start, and it keeps stepping while advance stays low.
- R11: A strobe that loads takes priority over advance. A new capture in the middle of a burst restarts the burst at beat 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 1 | Burst order: 1 = interleaved, 0 = linear |
| ce_n_i | input | 1 | Primary chip enable, active low; gates the processor strobe |
| proc_strobe_n_i | input | 1 | Processor-side address-status strobe, active low |
| ctrl_strobe_n_i | input | 1 | Controller-side address-status strobe, active low |
| adv_n_i | input | 1 | Burst advance, active low |
| addr_i | input | 17 | External word address |
| addr_o | output | 17 | Current burst word address |
| beat_o | output | 2 | Current beat count |

## Verification
A load, an advance or a suspend sampled at one rising edge is visible on addr_o and beat_o straight after that same edge, through one register stage. The only exception is a change of mode_i, which reaches addr_o[1:0] at once through combinational logic. The driver applies each command on a falling edge and queues the outcome a reference model predicts from the requirements. The monitor pops one item for each rising edge, 2 ns after that edge, so every comparison falls in the cycle that the command decides and well clear of the next command.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  typedef enum logic {
    ORDER_LINEAR      = 1'b0,
    ORDER_INTERLEAVED = 1'b1
  } order_e;
endpackage

// File: rtl/burst_cmd_dec.sv
module burst_cmd_dec (
  input  logic ce_n_i,
  input  logic proc_strobe_n_i,
  input  logic ctrl_strobe_n_i,
  input  logic adv_n_i,
  output logic load_o,
  output logic step_o
);
  logic proc_ok;

  // processor strobe is masked while the chip is deselected
  assign proc_ok = ~proc_strobe_n_i & ~ce_n_i;
  assign load_o  = ~ctrl_strobe_n_i | proc_ok;
  assign step_o  = ctrl_strobe_n_i & proc_strobe_n_i & ~adv_n_i;
endmodule

// File: rtl/burst_addr_reg.sv
module burst_addr_reg #(
  parameter int ADDR_W = 17
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] base_o
);
  logic [ADDR_W-1:0] base_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     base_q <= '0;
    else if (load_i) base_q <= addr_i;
  end

  assign base_o = base_q;

  a_r4_base_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(base_q));
endmodule

// File: rtl/burst_beat_cnt.sv
module burst_beat_cnt #(
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              step_i,
  output logic [BEAT_W-1:0] beat_o
);
  logic [BEAT_W-1:0] beat_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      beat_q <= '0;
    else if (load_i)  beat_q <= '0;
    else if (step_i)  beat_q <= beat_q + 1'b1;  // wraps, no end of burst
  end

  assign beat_o = beat_q;

  a_r11_load_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> beat_q == '0);
  a_r5_step_incr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !load_i) |=> beat_q == BEAT_W'($past(beat_q) + 1'b1));
  a_r6_suspend_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!step_i && !load_i) |=> $stable(beat_q));
endmodule

// File: rtl/burst_order_gen.sv
module burst_order_gen #(
  parameter int BEAT_W = 2
) (
  input  burst_seq_pkg::order_e order_i,
  input  logic [BEAT_W-1:0]     start_i,
  input  logic [BEAT_W-1:0]     beat_i,
  output logic [BEAT_W-1:0]     low_o
);
  logic [BEAT_W-1:0] lin_low;
  logic [BEAT_W-1:0] ilv_low;

  assign lin_low = start_i + beat_i;
  assign ilv_low = start_i ^ beat_i;
  assign low_o   = (order_i == burst_seq_pkg::ORDER_INTERLEAVED) ? ilv_low : lin_low;
endmodule

// File: rtl/burst_seq.sv
module burst_seq #(
  parameter int ADDR_W = 17,
  parameter int BEAT_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              mode_i,
  input  logic              ce_n_i,
  input  logic              proc_strobe_n_i,
  input  logic              ctrl_strobe_n_i,
  input  logic              adv_n_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BEAT_W-1:0] beat_o
);
  localparam int HI_W = ADDR_W - BEAT_W;

  logic              load, step;
  logic [ADDR_W-1:0] base;
  logic [BEAT_W-1:0] beat;
  logic [BEAT_W-1:0] low;
  burst_seq_pkg::order_e order;

  assign order = burst_seq_pkg::order_e'(mode_i);

  burst_cmd_dec u_dec (
    .ce_n_i          (ce_n_i),
    .proc_strobe_n_i (proc_strobe_n_i),
    .ctrl_strobe_n_i (ctrl_strobe_n_i),
    .adv_n_i         (adv_n_i),
    .load_o          (load),
    .step_o          (step)
  );

  burst_addr_reg #(.ADDR_W(ADDR_W)) u_areg (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .addr_i (addr_i),
    .base_o (base)
  );

  burst_beat_cnt #(.BEAT_W(BEAT_W)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .load_i (load),
    .step_i (step),
    .beat_o (beat)
  );

  burst_order_gen #(.BEAT_W(BEAT_W)) u_ord (
    .order_i (order),
    .start_i (base[BEAT_W-1:0]),
    .beat_i  (beat),
    .low_o   (low)
  );

  assign addr_o = {base[ADDR_W-1:BEAT_W], low};
  assign beat_o = beat;

  a_r2_ctrl_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_strobe_n_i |=> (addr_o == $past(addr_i)) && (beat_o == '0));
  a_r3_proc_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!proc_strobe_n_i && !ce_n_i) |=> (addr_o == $past(addr_i)) && (beat_o == '0));
  a_r4_proc_masked: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctrl_strobe_n_i && !proc_strobe_n_i && ce_n_i) |=> $stable(beat_o));
  a_r9_upper_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load |=> addr_o[ADDR_W-1:BEAT_W] == $past(addr_o[ADDR_W-1:BEAT_W]));
  a_r1_reset_zero: assert property (@(posedge clk_i)
    !rst_ni |-> (addr_o == '0) && (beat_o == '0));

  initial begin
    assert (HI_W > 0);
  end
endmodule

// File: tb/burst_seq_tb.sv
module burst_seq_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        mode = 1'b1;
  logic        ce_n = 1'b1;
  logic        proc_n = 1'b1;
  logic        ctrl_n = 1'b1;
  logic        adv_n = 1'b1;
  logic [16:0] addr_in = '0;
  logic [16:0] addr_out;
  logic [1:0]  beat_out;

  int checks = 0;
  int errors = 0;

  logic [16:0] m_base = '0;
  logic [1:0]  m_beat = '0;

  logic [18:0] q_exp[$];
  string       q_tag[$];
  bit          run = 1'b0;

  always #5 clk = ~clk;

  burst_seq u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .mode_i          (mode),
    .ce_n_i          (ce_n),
    .proc_strobe_n_i (proc_n),
    .ctrl_strobe_n_i (ctrl_n),
    .adv_n_i         (adv_n),
    .addr_i          (addr_in),
    .addr_o          (addr_out),
    .beat_o          (beat_out)
  );

  function automatic logic [16:0] model_addr();
    logic [1:0] lo;
    lo = mode ? (m_base[1:0] ^ m_beat) : (m_base[1:0] + m_beat);
    return {m_base[16:2], lo};
  endfunction

  task automatic compare(input string tag, input logic [18:0] exp);
    checks++;
    if ({addr_out, beat_out} !== exp) begin
      errors++;
      $display("FAIL %s: addr=%h beat=%0d expected addr=%h beat=%0d",
               tag, addr_out, beat_out, exp[18:2], exp[1:0]);
    end
  endtask

  // drive one command on the falling edge and queue its outcome
  task automatic step(input logic c_n, input logic p_n, input logic e_n,
                      input logic a_n, input logic [16:0] a, input string tag);
    @(negedge clk);
    ctrl_n = c_n; proc_n = p_n; ce_n = e_n; adv_n = a_n; addr_in = a;
    if (!c_n || (!p_n && !e_n)) begin
      m_base = a;
      m_beat = 2'd0;
    end else if (c_n && p_n && !a_n) begin
      m_beat = m_beat + 2'd1;
    end
    q_exp.push_back({model_addr(), m_beat});
    q_tag.push_back(tag);
  endtask

  // monitor: one result due after every rising edge
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (run && q_exp.size() > 0) compare(q_tag.pop_front(), q_exp.pop_front());
    end
  end

  task automatic finish_run();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL watchdog: actual=hung expected=done");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    compare("R1", 19'd0);
    @(negedge clk);
    rst_ni = 1'b1;
    run = 1'b1;

    // interleaved, controller load with chip deselected, start 01
    mode = 1'b1;
    step(0, 1, 1, 1, 17'h1ABCD, "R2");
    step(1, 1, 1, 0, 17'h00000, "R7 R9");
    step(1, 1, 1, 0, 17'h00000, "R7 R9");
    step(1, 1, 1, 0, 17'h00000, "R7 R9");
    step(1, 1, 1, 0, 17'h00000, "R10");
    step(1, 1, 1, 0, 17'h00000, "R10");
    step(1, 1, 1, 1, 17'h00000, "R6");
    step(1, 1, 1, 1, 17'h15555, "R6");

    // interleaved from 11
    step(0, 1, 0, 1, 17'h0FFFF, "R2");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 17'h0, "R7");

    // linear, processor load with chip selected, start 10
    @(negedge clk);
    mode = 1'b0;
    step(1, 0, 0, 1, 17'h0F3E2, "R3");
    for (int i = 0; i < 5; i++) step(1, 1, 0, 0, 17'h0, "R8 R10");

    // masked processor strobe
    step(1, 0, 1, 0, 17'h12345, "R4");
    step(1, 0, 1, 1, 17'h00003, "R4");
    step(1, 1, 1, 0, 17'h0, "R8");

    // linear from 11, then reload mid-burst
    step(1, 0, 0, 0, 17'h00A07, "R3");
    step(1, 1, 0, 0, 17'h0, "R8");
    step(1, 1, 0, 0, 17'h0, "R8");
    step(0, 1, 0, 0, 17'h1C001, "R11");
    step(1, 1, 0, 0, 17'h0, "R8 R9");
    step(1, 0, 0, 0, 17'h03332, "R11");
    step(1, 1, 0, 1, 17'h0, "R6");

    // interleaved from 00 and 10
    @(negedge clk);
    mode = 1'b1;
    step(0, 1, 0, 0, 17'h10000, "R2 R11");
    for (int i = 0; i < 3; i++) step(1, 1, 0, 0, 17'h0, "R7");
    step(0, 1, 0, 1, 17'h0ABC2, "R2");
    for (int i = 0; i < 4; i++) step(1, 1, 0, 0, 17'h0, "R7 R10");

    @(negedge clk);
    ctrl_n = 1'b1; proc_n = 1'b1; adv_n = 1'b1;
    while (q_exp.size() > 0) @(negedge clk);
    @(negedge clk);
    finish_run();
  end
endmodule